// File: doc/BRIEF.md
# PLL Lock and Enable Sequencer

This block brings a frequency synthesizer from a fresh divider setting to running, ungated outputs. It is the master on a simple register bus into the synthesizer's controller. A single `start` pulse latches a configuration: the input divider N, the feedback multiplier M, up to four post-divider values and the internal comparison frequency in Hz. A post-divider value of zero marks that output as unused.

The sequencer first programs the divider words, with every post-divided output gated and the post-dividers bypassed. It then issues an update command and waits for the loop to lock. After lock it ungates the outputs that are in use and waits for each of them to acknowledge.

Lock can be awaited in one of two ways. In the first, the sequencer polls until the update bit clears and the lock flag rises, each under a cycle timeout. In the second, it repeats the update command with a fixed wait per attempt and a strict qualification of the whole status word. While the sequence runs the block holds `busy`. It ends with a one-cycle `done` pulse and a two-bit result code.

Top module: `pll_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are all 0.
- R2: The first bus write goes to address 3, the divider word. It holds N−1 in bits 7:0, M in bits 19:8, post-divider 0 minus 1 in bits 24:20 and post-divider 1 minus 1 in bits 29:25. A post-divider of zero is written as field value 0. All other bits are 0.
- R3: The second write goes to address 5. It holds post-divider 2 minus 1 in bits 4:0 and post-divider 3 minus 1 in bits 9:5, with zero-valued dividers written as 0. All other bits are 0.
- R4: The third write goes to address 4, the control word. It has bit 13 set, bit 20 (post-divider bypass) set, the frequency code in bits 4:1, and every other bit 0, including bits 14, 16, 18, 23 and 25. The fourth write writes 1 to address 2, the update register.
- R5: The frequency code is 3 for an internal frequency below 1 000 000 Hz. It is 4 below 1 250 000 Hz, 5 below 1 500 000 Hz, 6 below 1 750 000 Hz, and 7 otherwise.
- R6: With `retry_mode` at 0, the block reads address 2 until bit 0 is 0, and then reads address 1, the status word, until bit 1 is 1. Each poll gives up once TIMEOUT_CYC cycles have passed in that phase. The result code is then 1 (update stuck) or 2 (no lock), and no further writes follow.
- R7: With `retry_mode` at 1, an attempt succeeds only if the status word masked with 0x6F equals 0x03 and bit 0 of address 2 reads 0. This means bits 0 and 1 must be set, and bits 2, 3, 5 and 6 must be clear. Bit 4 and bits above 6 have no effect.
- R8: In retry mode, each attempt writes 1 to address 2 and then waits WAIT_CYC cycles. It then reads the status word, followed by address 2. The status read request is seen by the bus WAIT_CYC+2 cycles after the update write is taken. After RETRIES failed attempts the result code is 2.
- R9: After lock, the block writes address 4 again with bits 13 and 14 set and bit 20 clear, and with the frequency code in bits 4:1. Bits 16, 18, 23 and 25 are set exactly when post-divider 0, 1, 2 or 3 respectively is nonzero.
- R10: The block then reads the status word until bits 7, 8, 10 and 11 are all 1 for the outputs in use (post-dividers 0, 1, 2, 3 in that order). Acknowledge bits of unused outputs are ignored. If ACK_POLLS reads all fall short, the result code is 3; otherwise it is 0.
- R11: `busy` is 1 from the cycle after an accepted `start` until the sequence ends. `done` is then 1 for exactly one cycle with `busy` at 0. `err` holds the result code from that cycle until the next start.
- R12: Once `bus_req` is raised, it stays at 1 with address, direction and write data unchanged until the cycle in which `bus_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence; accepted while idle |
| retry_mode | input | 1 | 1 selects repeated update attempts with fixed waits |
| cfg_n | input | NW | Input divider N (1 or more) |
| cfg_m | input | MW | Feedback multiplier M |
| cfg_div | input | 4*DW | Four post-divider values, divider i in bits i*DW +: DW, 0 = unused |
| cfg_fint | input | 32 | Internal comparison frequency in Hz |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 3 | Register word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access completion, one cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 2 | Result: 0 ok, 1 update stuck, 2 no lock, 3 missing acknowledge |

## Verification
`busy` is due one cycle after the clock edge that samples `start`. The bench drives `start` for one cycle between edges and reads `busy` at the following falling edge. Every bus access takes two cycles against the bench's register model, so the only fixed bus delay the bench asserts is the retry wait. It measures the retry wait as WAIT_CYC+2 cycles between the edges at which the model takes the update write and the status read. The result code and the recorded bus writes are read at the falling edge where `done` is first seen high. Poll and attempt counts are tallied by the model itself and compared with ACK_POLLS and RETRIES.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 3;

  localparam logic [BUS_AW-1:0] A_STAT = 3'd1;
  localparam logic [BUS_AW-1:0] A_GO   = 3'd2;
  localparam logic [BUS_AW-1:0] A_DIV  = 3'd3;
  localparam logic [BUS_AW-1:0] A_CTL  = 3'd4;
  localparam logic [BUS_AW-1:0] A_POST = 3'd5;

  localparam int unsigned B_REFON  = 13;
  localparam int unsigned B_PHYIN  = 14;
  localparam int unsigned B_BYPASS = 20;

  localparam int unsigned EN_POS  [4] = '{16, 18, 23, 25};
  localparam int unsigned ACK_POS [4] = '{7, 8, 10, 11};

  typedef enum logic [3:0] {
    S_IDLE, S_WR_DIV, S_WR_POST, S_WR_CTL1, S_WR_GO, S_RD_GO, S_RD_LOCK,
    S_WAIT, S_RD_STAT, S_RD_GOCHK, S_WR_CTL2, S_RD_ACK, S_FIN
  } seq_state_t;

  typedef enum logic [1:0] {E_NONE, E_GO, E_LOCK, E_ACK} seq_err_t;

  function automatic logic [3:0] freq_code(input logic [31:0] hz);
    if (hz < 32'd1000000)      return 4'd3;
    else if (hz < 32'd1250000) return 4'd4;
    else if (hz < 32'd1500000) return 4'd5;
    else if (hz < 32'd1750000) return 4'd6;
    else                       return 4'd7;
  endfunction

  function automatic logic stat_locked(input logic [6:0] s);
    return (s & 7'h6F) == 7'h03;
  endfunction

endpackage

// File: rtl/pll_seq_fmt.sv
module pll_seq_fmt
  import pll_seq_pkg::*;
#(
  parameter int unsigned NW = 8,
  parameter int unsigned MW = 12,
  parameter int unsigned DW = 5
) (
  input  logic [NW-1:0]   n_val,
  input  logic [MW-1:0]   m_val,
  input  logic [4*DW-1:0] div_val,
  input  logic [31:0]     fint_hz,
  output logic [31:0]     w_div,
  output logic [31:0]     w_post,
  output logic [31:0]     w_ctl1,
  output logic [31:0]     w_ctl2,
  output logic [31:0]     ack_mask
);

  logic [DW-1:0] dm [4];
  logic [3:0]    used;
  logic [3:0]    fc;

  for (genvar i = 0; i < 4; i++) begin : g_div
    assign used[i] = div_val[i*DW +: DW] != '0;
    assign dm[i]   = used[i] ? div_val[i*DW +: DW] - 1'b1 : '0;
  end

  assign fc = freq_code(fint_hz);

  assign w_div  = 32'(n_val - 1'b1)
                | (32'(m_val) << NW)
                | (32'(dm[0]) << (NW + MW))
                | (32'(dm[1]) << (NW + MW + DW));
  assign w_post = 32'(dm[2]) | (32'(dm[3]) << DW);
  assign w_ctl1 = (32'd1 << B_REFON) | (32'd1 << B_BYPASS) | (32'(fc) << 1);

  always_comb begin
    w_ctl2   = (32'd1 << B_REFON) | (32'd1 << B_PHYIN) | (32'(fc) << 1);
    ack_mask = '0;
    for (int i = 0; i < 4; i++) begin
      w_ctl2[EN_POS[i]]    = used[i];
      ack_mask[ACK_POS[i]] = used[i];
    end
  end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q <= '0;
    else if (clr)                q <= '0;
    else if (inc && (q != '1))   q <= q + 1'b1;
  end

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 4096,
  parameter int unsigned WAIT_CYC    = 1000,
  parameter int unsigned RETRIES     = 20,
  parameter int unsigned ACK_POLLS   = 100,
  parameter int unsigned CW          = 13,
  parameter int unsigned KW          = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              retry,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  input  logic [31:0]       w_div,
  input  logic [31:0]       w_post,
  input  logic [31:0]       w_ctl1,
  input  logic [31:0]       w_ctl2,
  input  logic [31:0]       ack_mask,
  input  logic [CW-1:0]     cyc,
  input  logic [KW-1:0]     cnt,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic              accept,
  output logic              cyc_clr,
  output logic              cnt_clr,
  output logic              cnt_inc
);

  localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_CYC - 1);
  localparam logic [KW-1:0] RETRY_LAST = KW'(RETRIES - 1);
  localparam logic [KW-1:0] POLL_LAST  = KW'(ACK_POLLS - 1);

  seq_state_t state_q, state_d;
  seq_err_t   err_q, err_d;
  logic       err_ld, stat_ld;
  logic [6:0] stat_q;

  always_comb begin
    state_d = state_q;
    err_d   = E_NONE;
    err_ld  = 1'b0;
    stat_ld = 1'b0;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        state_d = S_WR_DIV;
        err_ld  = 1'b1;
        cnt_clr = 1'b1;
      end
      S_WR_DIV:  if (bus_ack) state_d = S_WR_POST;
      S_WR_POST: if (bus_ack) state_d = S_WR_CTL1;
      S_WR_CTL1: if (bus_ack) state_d = S_WR_GO;
      S_WR_GO:   if (bus_ack) state_d = retry ? S_WAIT : S_RD_GO;
      S_RD_GO: if (bus_ack) begin
        if (!bus_rdata[0]) state_d = S_RD_LOCK;
        else if (cyc >= TMO_LAST) begin
          state_d = S_FIN; err_ld = 1'b1; err_d = E_GO;
        end
      end
      S_RD_LOCK: if (bus_ack) begin
        if (bus_rdata[1]) state_d = S_WR_CTL2;
        else if (cyc >= TMO_LAST) begin
          state_d = S_FIN; err_ld = 1'b1; err_d = E_LOCK;
        end
      end
      S_WAIT: if (cyc == WAIT_LAST) state_d = S_RD_STAT;
      S_RD_STAT: if (bus_ack) begin
        stat_ld = 1'b1;
        state_d = S_RD_GOCHK;
      end
      S_RD_GOCHK: if (bus_ack) begin
        if (stat_locked(stat_q) && !bus_rdata[0]) state_d = S_WR_CTL2;
        else if (cnt == RETRY_LAST) begin
          state_d = S_FIN; err_ld = 1'b1; err_d = E_LOCK;
        end else begin
          cnt_inc = 1'b1;
          state_d = S_WR_GO;
        end
      end
      S_WR_CTL2: if (bus_ack) begin
        cnt_clr = 1'b1;
        state_d = S_RD_ACK;
      end
      S_RD_ACK: if (bus_ack) begin
        if ((bus_rdata & ack_mask) == ack_mask) state_d = S_FIN;
        else if (cnt == POLL_LAST) begin
          state_d = S_FIN; err_ld = 1'b1; err_d = E_ACK;
        end else cnt_inc = 1'b1;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign cyc_clr = state_d != state_q;
  assign accept  = (state_q == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      err_q   <= E_NONE;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (err_ld)  err_q  <= err_d;
      if (stat_ld) stat_q <= bus_rdata[6:0];
    end
  end

  always_comb begin
    bus_req   = 1'b1;
    bus_we    = 1'b0;
    bus_addr  = A_STAT;
    bus_wdata = '0;
    unique case (state_q)
      S_WR_DIV:   begin bus_we = 1'b1; bus_addr = A_DIV;  bus_wdata = w_div;  end
      S_WR_POST:  begin bus_we = 1'b1; bus_addr = A_POST; bus_wdata = w_post; end
      S_WR_CTL1:  begin bus_we = 1'b1; bus_addr = A_CTL;  bus_wdata = w_ctl1; end
      S_WR_GO:    begin bus_we = 1'b1; bus_addr = A_GO;   bus_wdata = 32'd1;  end
      S_WR_CTL2:  begin bus_we = 1'b1; bus_addr = A_CTL;  bus_wdata = w_ctl2; end
      S_RD_GO, S_RD_GOCHK: bus_addr = A_GO;
      S_RD_LOCK, S_RD_STAT, S_RD_ACK: bus_addr = A_STAT;
      default:    bus_req = 1'b0;
    endcase
  end

  assign busy = (state_q != S_IDLE) && (state_q != S_FIN);
  assign done = state_q == S_FIN;
  assign err  = err_q;

endmodule

// File: rtl/pll_seq.sv
module pll_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned NW          = 8,
  parameter int unsigned MW          = 12,
  parameter int unsigned DW          = 5,
  parameter int unsigned TIMEOUT_CYC = 4096,
  parameter int unsigned WAIT_CYC    = 1000,
  parameter int unsigned RETRIES     = 20,
  parameter int unsigned ACK_POLLS   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              retry_mode,
  input  logic [NW-1:0]     cfg_n,
  input  logic [MW-1:0]     cfg_m,
  input  logic [4*DW-1:0]   cfg_div,
  input  logic [31:0]       cfg_fint,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err
);

  localparam int unsigned CYC_MAX = (TIMEOUT_CYC > WAIT_CYC) ? TIMEOUT_CYC : WAIT_CYC;
  localparam int unsigned CNT_MAX = (RETRIES > ACK_POLLS) ? RETRIES : ACK_POLLS;
  localparam int unsigned CW      = $clog2(CYC_MAX + 1);
  localparam int unsigned KW      = $clog2(CNT_MAX + 1);

  logic [1:0]      rs_q;
  logic            rst_q;
  logic [NW-1:0]   n_q;
  logic [MW-1:0]   m_q;
  logic [4*DW-1:0] div_q;
  logic [31:0]     fint_q;
  logic            retry_q;
  logic            accept, cyc_clr, cnt_clr, cnt_inc;
  logic [CW-1:0]   cyc;
  logic [KW-1:0]   cnt;
  logic [31:0]     w_div, w_post, w_ctl1, w_ctl2, ack_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      n_q     <= '0;
      m_q     <= '0;
      div_q   <= '0;
      fint_q  <= '0;
      retry_q <= 1'b0;
    end else if (accept) begin
      n_q     <= cfg_n;
      m_q     <= cfg_m;
      div_q   <= cfg_div;
      fint_q  <= cfg_fint;
      retry_q <= retry_mode;
    end
  end

  pll_seq_fmt #(.NW(NW), .MW(MW), .DW(DW)) u_fmt (
    .n_val(n_q), .m_val(m_q), .div_val(div_q), .fint_hz(fint_q),
    .w_div(w_div), .w_post(w_post), .w_ctl1(w_ctl1), .w_ctl2(w_ctl2),
    .ack_mask(ack_mask)
  );

  pll_seq_timer #(.W(CW)) u_cyc (
    .clk(clk), .rst_n(rst_q), .clr(cyc_clr), .inc(1'b1), .q(cyc)
  );

  pll_seq_timer #(.W(KW)) u_cnt (
    .clk(clk), .rst_n(rst_q), .clr(cnt_clr), .inc(cnt_inc), .q(cnt)
  );

  pll_seq_fsm #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .WAIT_CYC(WAIT_CYC), .RETRIES(RETRIES),
    .ACK_POLLS(ACK_POLLS), .CW(CW), .KW(KW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_q), .start(start), .retry(retry_q),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .w_div(w_div), .w_post(w_post), .w_ctl1(w_ctl1), .w_ctl2(w_ctl2),
    .ack_mask(ack_mask), .cyc(cyc), .cnt(cnt),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .done(done), .err(err),
    .accept(accept), .cyc_clr(cyc_clr), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
  );

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [1:0]  err,
  input logic        bus_req,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack
);

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: done closes a busy sequence
  p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R11: an accepted start raises busy
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  // R11: result code holds while idle
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !start) |=> $stable(err));

  // R12: request held stable until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                               $stable(bus_addr) && $stable(bus_wdata)));

  // R1: no bus traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

endmodule

bind pll_seq pll_seq_chk u_chk (
  .clk(clk), .rst_n(rst_q), .start(start), .busy(busy), .done(done),
  .err(err), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/sim_pll_seq.sv
`timescale 1ns/1ps
module sim_pll_seq;

  localparam int TMO  = 64;
  localparam int WAIT = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, retry_mode;
  logic [7:0]  cfg_n;
  logic [11:0] cfg_m;
  logic [19:0] cfg_div;
  logic [31:0] cfg_fint;
  logic        bus_req, bus_we, bus_ack;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        busy, done;
  logic [1:0]  err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pll_seq #(.TIMEOUT_CYC(TMO), .WAIT_CYC(WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .retry_mode(retry_mode),
    .cfg_n(cfg_n), .cfg_m(cfg_m), .cfg_div(cfg_div), .cfg_fint(cfg_fint),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .done(done), .err(err)
  );

  // register model knobs (bench-driven)
  int          go_after;   // reads of 1 before GO reads 0; -1 = never clears
  bit          lock_en;
  int          lock_after; // GO writes needed before lock shows
  logic [31:0] st_set, st_clr;
  logic        clr_model;

  // register model state (model-driven)
  int          go_w, go_r, c2_cnt, nwr, n_ack_rd, t_go, st_gap, cyc_no;
  logic [31:0] c2_last;
  logic [2:0]  wlog_a [64];
  logic [31:0] wlog_d [64];
  logic [31:0] stat_now;
  logic        go_val;

  assign go_val = (go_after < 0) ? 1'b1 : (go_r < go_after);

  always_comb begin
    stat_now = 32'h1 | st_set;
    if (lock_en && go_w >= lock_after) stat_now[1] = 1'b1;
    if (c2_cnt >= 2) begin
      stat_now[7]  = stat_now[7]  | c2_last[16];
      stat_now[8]  = stat_now[8]  | c2_last[18];
      stat_now[10] = stat_now[10] | c2_last[23];
      stat_now[11] = stat_now[11] | c2_last[25];
    end
    stat_now = stat_now & ~st_clr;
  end

  always @(posedge clk) cyc_no <= cyc_no + 1;
  initial cyc_no = 0;

  always @(posedge clk) begin
    bus_ack <= 1'b0;
    if (clr_model) begin
      go_w <= 0; go_r <= 0; c2_cnt <= 0; nwr <= 0; n_ack_rd <= 0;
      t_go <= 0; st_gap <= -1; c2_last <= '0; bus_rdata <= '0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        if (nwr < 64) begin wlog_a[nwr] <= bus_addr; wlog_d[nwr] <= bus_wdata; end
        nwr <= nwr + 1;
        if (bus_addr == 3'd2 && bus_wdata[0]) begin
          go_w <= go_w + 1; go_r <= 0; t_go <= cyc_no;
        end
        if (bus_addr == 3'd4) begin c2_cnt <= c2_cnt + 1; c2_last <= bus_wdata; end
      end else if (bus_addr == 3'd2) begin
        bus_rdata <= {31'b0, go_val};
        go_r <= go_r + 1;
      end else begin
        bus_rdata <= stat_now;
        if (c2_cnt >= 2) n_ack_rd <= n_ack_rd + 1;
        else if (st_gap < 0) st_gap <= cyc_no - t_go;
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [3:0] fcode(input int f);
    if (f < 1000000) return 4'd3;
    if (f < 1250000) return 4'd4;
    if (f < 1500000) return 4'd5;
    if (f < 1750000) return 4'd6;
    return 4'd7;
  endfunction

  function automatic logic [4:0] dmin(input logic [4:0] d);
    return (d == 0) ? 5'd0 : d - 5'd1;
  endfunction

  function automatic logic [31:0] e_div(input int n, input int m, input logic [19:0] dv);
    return (32'(n - 1) & 32'hFF) | (32'(m) << 8) | (32'(dmin(dv[4:0])) << 20)
         | (32'(dmin(dv[9:5])) << 25);
  endfunction

  function automatic logic [31:0] e_post(input logic [19:0] dv);
    return 32'(dmin(dv[14:10])) | (32'(dmin(dv[19:15])) << 5);
  endfunction

  function automatic logic [31:0] e_ctl1(input int f);
    return 32'h0010_2000 | (32'(fcode(f)) << 1);
  endfunction

  function automatic logic [31:0] e_ctl2(input int f, input logic [19:0] dv);
    logic [31:0] w;
    w = 32'h0000_6000 | (32'(fcode(f)) << 1);
    w[16] = dv[4:0] != 0;
    w[18] = dv[9:5] != 0;
    w[23] = dv[14:10] != 0;
    w[25] = dv[19:15] != 0;
    return w;
  endfunction

  task automatic knobs(input int ga, input bit le, input int la,
                       input logic [31:0] ss, input logic [31:0] sc);
    go_after = ga; lock_en = le; lock_after = la; st_set = ss; st_clr = sc;
  endtask

  task automatic run(input int n, input int m, input logic [19:0] dv, input int f,
                     input bit rt, input bit chk_busy, output logic [1:0] e);
    int k;
    @(negedge clk);
    clr_model = 1'b1;
    @(negedge clk);
    clr_model = 1'b0;
    cfg_n = 8'(n); cfg_m = 12'(m); cfg_div = dv; cfg_fint = 32'(f); retry_mode = rt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (chk_busy) check("R11 busy after start", {31'b0, busy}, 32'd1);
    k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual=no done expected=done");
    end else if (chk_busy) begin
      check("R11 busy low with done", {31'b0, busy}, 32'd0);
    end
    e = err;
    @(negedge clk);
    if (chk_busy) check("R11 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic chk_ok_run(input int n, input int m, input logic [19:0] dv,
                            input int f, input bit chk_busy);
    logic [1:0] e;
    run(n, m, dv, f, 1'b0, chk_busy, e);
    check("R10 result ok", 32'(e), 32'd0);
    check("R6 write count", 32'(nwr), 32'd5);
    check("R2 divider word addr", 32'(wlog_a[0]), 32'd3);
    check("R2 divider word", wlog_d[0], e_div(n, m, dv));
    check("R3 post word addr", 32'(wlog_a[1]), 32'd5);
    check("R3 post word", wlog_d[1], e_post(dv));
    check("R4 first control addr", 32'(wlog_a[2]), 32'd4);
    check("R4 R5 first control", wlog_d[2], e_ctl1(f));
    check("R4 update write", {29'b0, wlog_a[3]} | (wlog_d[3] << 8), 32'h102);
    check("R9 second control addr", 32'(wlog_a[4]), 32'd4);
    check("R9 R5 second control", wlog_d[4], e_ctl2(f, dv));
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] e;
    int fl [8] = '{999999, 1000000, 1249999, 1250000, 1499999, 1500000, 1749999, 1750000};
    start = 0; retry_mode = 0; cfg_n = 1; cfg_m = 0; cfg_div = 0; cfg_fint = 0;
    clr_model = 1'b1;
    knobs(2, 1'b1, 1, 32'h0, 32'h0);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 busy in reset", {31'b0, busy}, 32'd0);
    check("R1 done in reset", {31'b0, done}, 32'd0);
    check("R1 req in reset", {31'b0, bus_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {29'b0, busy, done, bus_req}, 32'd0);

    // R2 R3 R4 R5 R9: all sixteen used/unused patterns, frequency steps
    for (int c = 0; c < 16; c++) begin
      logic [19:0] dv;
      for (int i = 0; i < 4; i++)
        dv[i*5 +: 5] = c[i] ? 5'(((c * 2 + i * 7) % 31) + 1) : 5'd0;
      chk_ok_run((c % 8) + 1, 100 + c * 13, dv, fl[c % 8], c == 0);
    end
    // boundary values: N max, divider max, divider of one
    chk_ok_run(255, 4095, {5'd31, 5'd1, 5'd31, 5'd1}, 2500000, 1'b0);

    // R6: update bit never clears
    knobs(-1, 1'b1, 1, 32'h0, 32'h0);
    run(3, 200, {5'd0, 5'd0, 5'd0, 5'd4}, 1200000, 1'b0, 1'b0, e);
    check("R6 update stuck code", 32'(e), 32'd1);
    check("R6 no write after stuck", 32'(nwr), 32'd4);
    // R6: no lock
    knobs(2, 1'b0, 1, 32'h0, 32'h0);
    run(3, 200, {5'd0, 5'd0, 5'd0, 5'd4}, 1200000, 1'b0, 1'b0, e);
    check("R6 no lock code", 32'(e), 32'd2);
    check("R6 no write after no lock", 32'(nwr), 32'd4);

    // R10: missing acknowledge on a used output
    knobs(2, 1'b1, 1, 32'h0, 32'h0000_0100);
    run(2, 90, {5'd0, 5'd0, 5'd3, 5'd2}, 1600000, 1'b0, 1'b0, e);
    check("R10 missing ack code", 32'(e), 32'd3);
    check("R10 ack poll count", 32'(n_ack_rd), 32'd100);
    // R10: missing acknowledge on an unused output is ignored
    knobs(2, 1'b1, 1, 32'h0, 32'h0000_0400);
    run(2, 90, {5'd0, 5'd0, 5'd3, 5'd2}, 1600000, 1'b0, 1'b0, e);
    check("R10 unused ack ignored", 32'(e), 32'd0);

    // R8: lock on third attempt, wait timing
    knobs(0, 1'b1, 3, 32'h0, 32'h0);
    run(4, 300, {5'd5, 5'd0, 5'd6, 5'd0}, 1300000, 1'b1, 1'b0, e);
    check("R8 retry success code", 32'(e), 32'd0);
    check("R8 attempts used", 32'(go_w), 32'd3);
    check("R8 status read gap", 32'(st_gap), 32'(WAIT + 2));
    check("R9 retry second control", wlog_d[nwr - 1], e_ctl2(1300000, {5'd5, 5'd0, 5'd6, 5'd0}));
    // R8: never locks, all attempts spent
    knobs(0, 1'b0, 1, 32'h0, 32'h0);
    run(4, 300, {5'd0, 5'd0, 5'd0, 5'd1}, 1300000, 1'b1, 1'b0, e);
    check("R8 retry fail code", 32'(e), 32'd2);
    check("R8 retry attempt count", 32'(go_w), 32'd20);
    // R7: each blocking status bit fails the attempt
    for (int b = 0; b < 7; b++) begin
      logic [31:0] ss, sc;
      if (b == 1 || b == 4) continue;
      ss = (b == 0) ? 32'h0 : (32'd1 << b);
      sc = (b == 0) ? 32'h1 : 32'h0;
      knobs(0, 1'b1, 1, ss, sc);
      run(5, 60, {5'd0, 5'd0, 5'd0, 5'd2}, 900000, 1'b1, 1'b0, e);
      check($sformatf("R7 status bit %0d blocks", b), 32'(e), 32'd2);
    end
    // R7: bit 4 and bit 9 have no effect
    knobs(0, 1'b1, 1, 32'h0000_0210, 32'h0);
    run(5, 60, {5'd0, 5'd0, 5'd0, 5'd2}, 900000, 1'b1, 1'b0, e);
    check("R7 ignored bits", 32'(e), 32'd0);
    check("R7 one attempt", 32'(go_w), 32'd1);
    // R7: locked status but update bit still set
    knobs(-1, 1'b1, 1, 32'h0, 32'h0);
    run(5, 60, {5'd0, 5'd0, 5'd0, 5'd2}, 900000, 1'b1, 1'b0, e);
    check("R7 update bit blocks", 32'(e), 32'd2);

    // R11: result code held while idle
    repeat (5) @(negedge clk);
    check("R11 err held", 32'(err), 32'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule